// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This peripheral counts down from a software-loaded start value. It steps once per prescaled tick. On expiry it raises a sticky timeout flag, reloads the start value and keeps running. The count engine runs from one of two sources, picked by a select bit: the bus clock or a slow always-on clock. The select works through a plain clock multiplexer, so the select bit is frozen while the timer runs. The tick is that source divided by a programmable 8-bit prescaler.

Software drives the timer through three bus registers. The usual sequence is:
1. Stop the timer and wait for the enable readback to fall.
2. Write the start value.
3. Set the enable and poll its readback until the count domain has taken the change.

Both the count and the timeout flag can be read back while the timer runs. The flag feeds an interrupt line and a wake line, and each has its own enable. The flag lives in the count domain, so the wake line keeps working when the bus clock is stopped.

Top module: `prescaled_interval_timer`

## Requirements
- R1: The prescaler register at byte offset 0x0 holds bits 7:0 of a write, and wider bits are dropped. With prescaler value N, a running counter drops by one every N+1 cycles of the selected source clock.
- R2: A tick that finds the count at 0 sets the timeout status and reloads the start value, and counting goes on. With start value P, expiries are (P+1)*(N+1) source cycles apart.
- R3: Control register, offset 0x4, bit 1 selects the count source: 0 for the bus clock, 1 for the slow clock. The bit can be written only while the enable bit (bit 0) and its readback are both 0.
- R4: Control bit 2 reads the timeout status. Writing 1 to it clears the status. Writing 0 leaves it unchanged, and the status stays set until it is cleared.
- R5: The irq output is status AND control bit 3. The wake output is status AND control bit 4. The wake output still rises on expiry while the bus clock is stopped.
- R6: Control bit 0 reads back the enable as the count domain has accepted it. The readback shows the old value for at least one bus cycle after a write, then follows within a bounded number of cycles. While the timer is disabled the count holds.
- R7: The count register, offset 0x8, accepts a write only while the enable bit and its readback are both 0. A write at any other time is dropped. The last value accepted becomes the count on each enable.
- R8: Offset 0x8 reads back the running count through a synchroniser. A value is valid once two consecutive reads agree, and valid values go down over time.
- R9: The counter width CNT_W is a parameter. A 16-bit instance keeps the low 16 bits of a start value, and a 32-bit instance keeps all 32.
- R10: After reset every register reads 0, and irq and wake are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also the fast count source |
| slow_clk | input | 1 | Slow always-on count source |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Timeout interrupt request |
| wake | output | 1 | Timeout wake-up request |

## Verification
The bench builds two instances that share one bus: the default 16-bit counter with an 8-bit prescaler, and a 32-bit counter. The shared bus lets a single start value show truncation on one instance and full width on the other. The slow clock is six bus cycles long, so expiry intervals can be measured in nanoseconds on both sources. It is long enough to let the bench stop the bus clock and still see a wake request. A prescaler of 255 slows the count enough that a readback taken just after enable must equal the loaded start value. That exposes whether a locked count write was dropped.

// File: rtl/prescaled_interval_timer.sv
module prescaled_interval_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic        clk,
  input  logic        slow_clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        wake
);
  localparam logic [3:0] A_PRE = 4'h0;
  localparam logic [3:0] A_CTL = 4'h4;
  localparam logic [3:0] A_CNT = 4'h8;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] preload;
  logic             en_req, cksel, ie, we, clr_tgl;
  logic [1:0]       en_s, sts_s;
  logic [CNT_W-1:0] cnt_s1, cnt_s2;

  logic [1:0]       en_c;
  logic             run_d;
  logic [2:0]       clr_c;
  logic [PRE_W-1:0] psc;
  logic [CNT_W-1:0] cnt_q;
  logic             to_flag;

  logic en_ack, idle, run, load, tick, clr_evt, expire, cnt_clk;
  logic unused_bits;

  assign en_ack      = en_s[1];
  assign idle        = !en_req && !en_ack;
  assign unused_bits = &{1'b0, wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      preload <= '0;
      en_req  <= 1'b0;
      cksel   <= 1'b0;
      ie      <= 1'b0;
      we      <= 1'b0;
      clr_tgl <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_PRE: pre_q <= wdata[PRE_W-1:0];
        A_CTL: begin
          en_req <= wdata[0];
          if (idle) cksel <= wdata[1];
          if (wdata[2]) clr_tgl <= ~clr_tgl;
          ie <= wdata[3];
          we <= wdata[4];
        end
        A_CNT: if (idle) preload <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s   <= '0;
      sts_s  <= '0;
      cnt_s1 <= '0;
      cnt_s2 <= '0;
    end else begin
      en_s   <= {en_s[0], run};
      sts_s  <= {sts_s[0], to_flag};
      cnt_s1 <= cnt_q;
      cnt_s2 <= cnt_s1;
    end
  end

  always_comb begin
    case (addr)
      A_PRE:   rdata = 32'(pre_q);
      A_CTL:   rdata = {27'b0, we, ie, sts_s[1], cksel, en_ack};
      A_CNT:   rdata = 32'(cnt_s2);
      default: rdata = '0;
    endcase
  end

  assign cnt_clk = cksel ? slow_clk : clk;

  assign run     = en_c[1];
  assign load    = run && !run_d;
  assign tick    = run && !load && (psc >= pre_q);
  assign expire  = tick && (cnt_q == '0);
  assign clr_evt = clr_c[2] ^ clr_c[1];

  always_ff @(posedge cnt_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_c    <= '0;
      run_d   <= 1'b0;
      clr_c   <= '0;
      psc     <= '0;
      cnt_q   <= '0;
      to_flag <= 1'b0;
    end else begin
      en_c  <= {en_c[0], en_req};
      run_d <= run;
      clr_c <= {clr_c[1:0], clr_tgl};
      if (load) begin
        cnt_q <= preload;
        psc   <= '0;
      end else if (tick) begin
        psc   <= '0;
        cnt_q <= (cnt_q == '0) ? preload : cnt_q - 1'b1;
      end else if (run) begin
        psc <= psc + 1'b1;
      end
      if (expire)       to_flag <= 1'b1;
      else if (clr_evt) to_flag <= 1'b0;
    end
  end

  assign irq  = to_flag && ie;
  assign wake = to_flag && we;

  AST_TICK_DECREMENT: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    (tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R1
  AST_EXPIRE_RELOAD: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    (tick && cnt_q == '0) |=> (cnt_q == $past(preload) && to_flag)); // R2
  AST_FLAG_STICKY: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    (to_flag && !clr_evt) |=> to_flag); // R4
  AST_HOLD_STOPPED: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q)); // R6
  AST_CKSEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req || en_ack) |=> $stable(cksel)); // R3
  AST_ZERO_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL && !wdata[2]) |=> $stable(clr_tgl)); // R4
  AST_COUNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CNT && (en_req || en_ack)) |=> $stable(preload)); // R7
endmodule

// File: tb/prescaled_interval_timer_bench.sv
`timescale 1ns/100ps
module prescaled_interval_timer_bench;
  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0, clk_run = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_n, rdata_w;
  logic irq_n, wake_n, irq_w, wake_w;
  int total = 0, fails = 0;

  always begin #2.5; if (clk_run) clk = ~clk; end
  always #15 slow_clk = ~slow_clk;

  prescaled_interval_timer u_prescaled_interval_timer (
    .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_n), .irq(irq_n), .wake(wake_n));

  prescaled_interval_timer #(.CNT_W(32)) u_prescaled_interval_timer_w32 (
    .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_w), .irq(irq_w), .wake(wake_w));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input bit wide, output logic [31:0] v);
    @(negedge clk); addr = a; #1;
    v = wide ? rdata_w : rdata_n;
  endtask

  task automatic rd_stable(input bit wide, output logic [31:0] v);
    logic [31:0] a, b;
    rd(4'h8, wide, a);
    for (int i = 0; i < 16; i++) begin
      rd(4'h8, wide, b);
      if (a == b) break;
      a = b;
    end
    v = b;
  endtask

  task automatic wait_ack(input bit val, input string tag);
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(4'h4, 1'b0, v);
      if (v[0] == val) break;
    end
    chk(v[0] == val, tag, v[0], val);
  endtask

  task automatic wait_sig(input bit lvl, input bit use_wake, input int max_ns, output longint t);
    t = -1;
    for (int i = 0; i < max_ns; i++) begin
      if ((use_wake ? wake_n : irq_n) == lvl) begin t = $time; break; end
      #1;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'h0, 1'b0, v); chk(v == 0, "R10 prescaler reset", v, 0);
    rd(4'h4, 1'b0, v); chk(v == 0, "R10 control reset", v, 0);
    rd(4'h8, 1'b0, v); chk(v == 0, "R10 count reset", v, 0);
    chk(!irq_n && !wake_n, "R10 irq/wake reset", {irq_n, wake_n}, 0);
  endtask

  task automatic t_fast_period;
    logic [31:0] v;
    longint t1, t2, tf;
    wr(4'h0, 32'h1A5);
    rd(4'h0, 1'b0, v); chk(v == 32'hA5, "R1 prescaler 8-bit field", v, 32'hA5);
    wr(4'h0, 32'h3);
    wr(4'h8, 32'd9);
    wr(4'h4, 32'h09);
    rd(4'h4, 1'b0, v); chk(v[0] == 1'b0, "R6 enable readback lags", v[0], 0);
    wait_ack(1'b1, "R6 enable accepted");
    wait_sig(1'b1, 1'b0, 2000, t1);
    wr(4'h4, 32'h0D);
    wait_sig(1'b0, 1'b0, 200, tf);
    chk(tf >= 0, "R4 clear drops irq", tf, 0);
    wait_sig(1'b1, 1'b0, 2000, t2);
    chk(t1 >= 0 && (t2 - t1) == 200, "R2 fast expiry interval ns", t2 - t1, 200);
    wr(4'h4, 32'h08);
    wait_ack(1'b0, "R6 disable accepted");
  endtask

  task automatic t_status;
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rd(4'h4, 1'b0, v); chk(v[2] == 1'b1, "R4 status set after expiry", v[2], 1);
    wr(4'h4, 32'h08);
    repeat (12) @(negedge clk);
    rd(4'h4, 1'b0, v); chk(v[2] == 1'b1, "R4 write 0 keeps status", v[2], 1);
    chk(irq_n, "R4 irq held after write 0", irq_n, 1);
    wr(4'h4, 32'h10);
    chk(!irq_n && wake_n, "R5 wake only", {irq_n, wake_n}, 2'b01);
    wr(4'h4, 32'h00);
    chk(!irq_n && !wake_n, "R5 both gated off", {irq_n, wake_n}, 0);
    wr(4'h4, 32'h18);
    chk(irq_n && wake_n, "R5 both on", {irq_n, wake_n}, 2'b11);
    wr(4'h4, 32'h1C);
    repeat (12) @(negedge clk);
    rd(4'h4, 1'b0, v); chk(v[2] == 1'b0, "R4 write 1 clears", v[2], 0);
    repeat (20) @(negedge clk);
    chk(!irq_n && !wake_n, "R4 stays clear", {irq_n, wake_n}, 0);
    wr(4'h4, 32'h00);
  endtask

  task automatic t_count_lock;
    logic [31:0] v;
    wr(4'h0, 32'hFF);
    wr(4'h8, 32'd100);
    wr(4'h4, 32'h01);
    wait_ack(1'b1, "R6 enable for lock test");
    wr(4'h8, 32'd7);
    wr(4'h4, 32'h00);
    wait_ack(1'b0, "R6 disable for lock test");
    wr(4'h4, 32'h01);
    wait_ack(1'b1, "R6 re-enable");
    rd_stable(1'b0, v); chk(v == 100, "R7 running write dropped", v, 100);
    wr(4'h4, 32'h00);
    wait_ack(1'b0, "R6 disable after lock test");
  endtask

  task automatic t_readback;
    logic [31:0] a, b;
    wr(4'h0, 32'h3);
    wr(4'h8, 32'd200);
    wr(4'h4, 32'h01);
    wait_ack(1'b1, "R6 enable for readback");
    rd_stable(1'b0, a);
    repeat (40) @(negedge clk);
    rd_stable(1'b0, b);
    chk(a <= 200 && a > b && (a - b) >= 9 && (a - b) <= 13, "R8 count decreasing", a - b, 10);
    wr(4'h4, 32'h00);
    wait_ack(1'b0, "R6 disable after readback");
    rd_stable(1'b0, a);
    repeat (40) @(negedge clk);
    rd_stable(1'b0, b);
    chk(a == b, "R6 count holds while disabled", b, a);
  endtask

  task automatic t_slow;
    logic [31:0] v;
    longint t1, t2, tf;
    wr(4'h0, 32'h1);
    wr(4'h8, 32'd4);
    wr(4'h4, 32'h0E);
    rd(4'h4, 1'b0, v); chk(v[1] == 1'b1, "R3 select slow source", v[1], 1);
    wait_sig(1'b0, 1'b0, 400, tf);
    wr(4'h4, 32'h0B);
    wait_ack(1'b1, "R6 enable on slow source");
    wr(4'h4, 32'h09);
    rd(4'h4, 1'b0, v); chk(v[1] == 1'b1, "R3 select locked while running", v[1], 1);
    wait_sig(1'b1, 1'b0, 2000, t1);
    wr(4'h4, 32'h0F);
    wait_sig(1'b0, 1'b0, 400, tf);
    wait_sig(1'b1, 1'b0, 2000, t2);
    chk(t1 >= 0 && (t2 - t1) == 300, "R3 slow expiry interval ns", t2 - t1, 300);
    wr(4'h4, 32'h1F);
    wait_sig(1'b0, 1'b1, 400, tf);
    @(negedge clk); clk_run = 1'b0;
    wait_sig(1'b1, 1'b1, 1000, t1);
    chk(t1 >= 0, "R5 wake with bus clock stopped", wake_n, 1);
    clk_run = 1'b1;
    wr(4'h4, 32'h06);
    wait_ack(1'b0, "R6 disable on slow source");
    wr(4'h4, 32'h04);
    rd(4'h4, 1'b0, v); chk(v[1] == 1'b0, "R3 select back to bus clock", v[1], 0);
  endtask

  task automatic t_width;
    logic [31:0] v;
    wr(4'h0, 32'hFF);
    wr(4'h8, 32'h0001_2345);
    wr(4'h4, 32'h01);
    wait_ack(1'b1, "R6 enable for width test");
    rd_stable(1'b1, v); chk(v == 32'h0001_2345, "R9 32-bit count", v, 32'h0001_2345);
    rd_stable(1'b0, v); chk(v == 32'h2345, "R9 16-bit count", v, 32'h2345);
    wr(4'h4, 32'h00);
    wait_ack(1'b0, "R6 disable after width test");
  endtask

  initial begin
    #500000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #22 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fast_period();
    t_status();
    t_count_lock();
    t_readback();
    t_slow();
    t_width();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule